// File: doc/BRIEF.md
# Five-Tone Summing IQ Baseband Generator

This block is one baseband channel of a multi-tone signal source. It holds five independent numerically controlled oscillators, each producing a complex sample from its own phase accumulator, phase offset and amplitude scale. The channel adds the five complex contributions and saturates the total to the signed 16-bit range. It then drops the two lowest bits and emits a 14-bit I and Q pair with a one-cycle valid pulse.

One shared cosine/sine generator and one scaler serve all five oscillators in turn. The sequencer has two states. S_IDLE waits for a synchronize strobe. On the transition START (S_IDLE to S_RUN) every accumulator advances. S_RUN then visits oscillators 0 to 4, one per clock, and adds each contribution. On the last oscillator it publishes the sample. It then takes either FINISH (S_RUN to S_IDLE, no strobe) or RESTART (S_RUN to S_RUN, strobe on the last cycle). Strobes in the other S_RUN cycles are ignored (HOLD, S_RUN to S_RUN). At a 125 MHz clock, a strobe every five cycles gives 25 MS/s. The same strobe fed to two channels keeps them in step.

Software-side configuration arrives as 32-bit writes. The address is {oscillator[2:0], sel}. sel=0 loads the frequency tuning word, and sel=1 loads the combined amplitude/clear/phase word.

Top module: `dds_sum_channel`

## Requirements
- R1: After reset, out_i, out_q and out_valid are 0. Every oscillator has tuning word 0, accumulator 0, phase offset 0, clear 0 and amplitude 0x7FFF.
- R2: A write with wr_addr = {osc, sel} and sel=0 loads oscillator osc's 32-bit tuning word, and sel=1 loads its amplitude/clear/phase word. Writes naming oscillators 5 to 7 change nothing.
- R3: In the amplitude/clear/phase word, bits [14:0] are the unsigned amplitude, bit 15 is the clear flag and bits [31:16] are the phase offset.
- R4: An accepted strobe adds each oscillator's tuning word to its accumulator (modulo 2^32). The oscillator's phase is accumulator[31:16] + phase offset (modulo 2^16).
- R5: With a 16-bit phase u, f = u[14:0] and m = min((f*(32768-f))>>13, 32767), sine(u) is m when u[15] is 0 and -m otherwise. cosine(u) = sine(u+0x4000).
- R6: The I contribution of an oscillator is (cosine*amplitude)>>>15, and the Q contribution is (sine*amplitude)>>>15 (arithmetic shift).
- R7: The five contributions of a component are summed and clamped to [-32768, 32767] instead of wrapping.
- R8: out_i/out_q are bits [15:2] of the clamped sums. out_valid is high for exactly the cycle after the fifth rising edge following the edge that accepted the strobe.
- R9: A strobe is accepted in S_IDLE or on the last S_RUN cycle. A strobe in any other cycle neither advances accumulators nor produces a sample.
- R10: While an oscillator's clear flag is 1, its accumulator is held at zero, also across strobes. After the flag is cleared, it resumes from zero.
- R11: A new tuning word is used from the next accepted strobe on, and writing one oscillator leaves the other oscillators' accumulators untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_stb | input | 1 | Synchronize strobe that starts a sample |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | {oscillator index, word select} |
| wr_data | input | 32 | Write data |
| out_i | output | 14 | In-phase sample |
| out_q | output | 14 | Quadrature sample |
| out_valid | output | 1 | One-cycle sample valid |

## Verification
A sample is due exactly five clock edges after the edge that accepts its strobe. A register write takes effect at the very edge it is presented, and a tuning word acts only at the following accepted strobe. The driver computes the acceptance edge of every strobe from its own edge count and the five-cycle busy window. It pushes the expected pair, together with its due edge, into a scoreboard. The monitor samples on falling edges and compares both value and arrival edge, so a sample that is early, late, extra or missing is reported. Writes are only issued while no sample is being accumulated, so each expected value follows from the register state the driver has modelled.

// File: rtl/dds_sum_pkg.sv
package dds_sum_pkg;

    // Sequencer states of the summing channel.
    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/dds_osc_bank.sv
module dds_osc_bank #(
    parameter int NUM_OSC = 5,
    parameter int ADDR_W  = 4,
    parameter int FTW_W   = 32,
    parameter int AMP_W   = 15,
    parameter int PH_W    = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en_i,
    input  logic [ADDR_W-1:0]                 wr_addr_i,
    input  logic [FTW_W-1:0]                  wr_data_i,
    input  logic                              advance_i,
    output logic [NUM_OSC-1:0][PH_W-1:0]      phase_o,
    output logic [NUM_OSC-1:0][AMP_W-1:0]     amp_o
);

    localparam int OSC_W   = ADDR_W - 1;
    localparam int CLR_BIT = AMP_W;
    localparam int POW_LSB = AMP_W + 1;

    logic [NUM_OSC-1:0][FTW_W-1:0] ftw_q;
    logic [NUM_OSC-1:0][FTW_W-1:0] acc_q;
    logic [NUM_OSC-1:0][PH_W-1:0]  pow_q;
    logic [NUM_OSC-1:0][AMP_W-1:0] amp_q;
    logic [NUM_OSC-1:0]            clr_q;
    logic [NUM_OSC-1:0]            hit_ftw;
    logic [NUM_OSC-1:0]            hit_word;

    // Per-oscillator address decode and phase formation.
    for (genvar n = 0; n < NUM_OSC; n++) begin : g_osc
        assign hit_ftw[n]  = wr_en_i && (wr_addr_i[ADDR_W-1:1] == OSC_W'(n)) && !wr_addr_i[0];
        assign hit_word[n] = wr_en_i && (wr_addr_i[ADDR_W-1:1] == OSC_W'(n)) &&  wr_addr_i[0];
        assign phase_o[n]  = acc_q[n][FTW_W-1 -: PH_W] + pow_q[n];

        // R10: a set clear flag forces the accumulator to zero on the next edge.
        a_r10_clear_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
            clr_q[n] |=> (acc_q[n] == '0));

        // R4: without a strobe or clear the accumulator keeps its value.
        a_r4_acc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            (!advance_i && !clr_q[n]) |=> $stable(acc_q[n]));
    end

    assign amp_o = amp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftw_q <= '0;
            acc_q <= '0;
            pow_q <= '0;
            clr_q <= '0;
            for (int n = 0; n < NUM_OSC; n++) begin
                amp_q[n] <= '1;
            end
        end else begin
            for (int n = 0; n < NUM_OSC; n++) begin
                if (hit_ftw[n]) begin
                    ftw_q[n] <= wr_data_i;
                end
                if (hit_word[n]) begin
                    amp_q[n] <= wr_data_i[AMP_W-1:0];
                    clr_q[n] <= wr_data_i[CLR_BIT];
                    pow_q[n] <= wr_data_i[POW_LSB +: PH_W];
                end
                if (clr_q[n]) begin
                    acc_q[n] <= '0;
                end else if (advance_i) begin
                    acc_q[n] <= acc_q[n] + ftw_q[n];
                end
            end
        end
    end

    // R2: writes naming an absent oscillator leave every register untouched.
    a_r2_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_addr_i[ADDR_W-1:1] >= OSC_W'(NUM_OSC)))
        |=> ($stable(ftw_q) && $stable(pow_q) && $stable(amp_q) && $stable(clr_q)));

endmodule

// File: rtl/dds_cossin.sv
module dds_cossin #(
    parameter int PH_W   = 16,
    parameter int WAVE_W = 16
) (
    input  logic [PH_W-1:0]   phase_i,
    output logic [WAVE_W-1:0] cos_o,
    output logic [WAVE_W-1:0] sin_o
);

    localparam int              FRAC_W    = PH_W - 1;
    localparam int              WIDE_W    = 2 * PH_W;
    localparam logic [PH_W-1:0] QUARTER   = PH_W'(1) << (PH_W - 2);
    localparam logic [WIDE_W-1:0] HALF_SPAN = WIDE_W'(1) << FRAC_W;
    localparam logic [WIDE_W-1:0] PEAK      = WIDE_W'((1 << (WAVE_W - 1)) - 1);

    // Parabolic half-wave: magnitude rises and falls over each half turn.
    function automatic logic [WAVE_W-1:0] half_wave(input logic [PH_W-1:0] u);
        logic [WIDE_W-1:0] f;
        logic [WIDE_W-1:0] prod;
        logic [WIDE_W-1:0] mag;
        f    = WIDE_W'(u[FRAC_W-1:0]);
        prod = f * (HALF_SPAN - f);
        mag  = prod >> (PH_W - 3);
        if (mag > PEAK) begin
            mag = PEAK;
        end
        return u[PH_W-1] ? (WAVE_W'(0) - WAVE_W'(mag)) : WAVE_W'(mag);
    endfunction

    logic [1:0][PH_W-1:0]   lane_ph;
    logic [1:0][WAVE_W-1:0] lane_w;

    // Lane 0 is the sine, lane 1 the cosine (sine shifted by a quarter turn).
    for (genvar l = 0; l < 2; l++) begin : g_lane
        assign lane_ph[l] = phase_i + (QUARTER * PH_W'(l));
        assign lane_w[l]  = half_wave(lane_ph[l]);
    end

    assign sin_o = lane_w[0];
    assign cos_o = lane_w[1];

endmodule

// File: rtl/dds_scale.sv
module dds_scale #(
    parameter int WAVE_W = 16,
    parameter int AMP_W  = 15
) (
    input  logic [1:0][WAVE_W-1:0] wave_i,
    input  logic [AMP_W-1:0]       amp_i,
    output logic [1:0][WAVE_W-1:0] scaled_o
);

    localparam int PROD_W = WAVE_W + AMP_W + 1;

    for (genvar l = 0; l < 2; l++) begin : g_lane
        logic signed [PROD_W-1:0] prod;
        assign prod        = PROD_W'($signed(wave_i[l])) * $signed({1'b0, amp_i});
        assign scaled_o[l] = WAVE_W'(prod >>> AMP_W);
    end

endmodule

// File: rtl/dds_sum_channel.sv
module dds_sum_channel
    import dds_sum_pkg::*;
#(
    parameter int NUM_OSC = 5,
    parameter int FTW_W   = 32,
    parameter int AMP_W   = 15,
    parameter int PH_W    = 16,
    parameter int WAVE_W  = 16,
    parameter int OUT_W   = 14,
    localparam int ADDR_W = $clog2(NUM_OSC) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_stb,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [FTW_W-1:0]  wr_data,
    output logic [OUT_W-1:0]  out_i,
    output logic [OUT_W-1:0]  out_q,
    output logic              out_valid
);

    localparam int IDX_W = $clog2(NUM_OSC);
    localparam int SUM_W = WAVE_W + $clog2(NUM_OSC) + 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_OSC - 1);
    localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((1 << (WAVE_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - 1;

    seq_state_e state_q, state_d;
    logic [IDX_W-1:0]                 idx_q;
    logic signed [SUM_W-1:0]          sum_i_q, sum_q_q;
    logic signed [SUM_W-1:0]          sum_i_d, sum_q_d;
    logic                             last, accept;
    logic [NUM_OSC-1:0][PH_W-1:0]     phase_v;
    logic [NUM_OSC-1:0][AMP_W-1:0]    amp_v;
    logic [WAVE_W-1:0]                cos_w, sin_w;
    logic [1:0][WAVE_W-1:0]           scaled;

    assign last   = (state_q == S_RUN) && (idx_q == LAST_IDX);
    assign accept = sync_stb && ((state_q == S_IDLE) || last);

    dds_osc_bank #(
        .NUM_OSC (NUM_OSC),
        .ADDR_W  (ADDR_W),
        .FTW_W   (FTW_W),
        .AMP_W   (AMP_W),
        .PH_W    (PH_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .advance_i (accept),
        .phase_o   (phase_v),
        .amp_o     (amp_v)
    );

    dds_cossin #(
        .PH_W   (PH_W),
        .WAVE_W (WAVE_W)
    ) u_wave (
        .phase_i (phase_v[idx_q]),
        .cos_o   (cos_w),
        .sin_o   (sin_w)
    );

    dds_scale #(
        .WAVE_W (WAVE_W),
        .AMP_W  (AMP_W)
    ) u_scale (
        .wave_i   ({sin_w, cos_w}),
        .amp_i    (amp_v[idx_q]),
        .scaled_o (scaled)
    );

    assign sum_i_d = sum_i_q + SUM_W'($signed(scaled[0]));
    assign sum_q_d = sum_q_q + SUM_W'($signed(scaled[1]));

    function automatic logic [OUT_W-1:0] clip(input logic signed [SUM_W-1:0] s);
        logic signed [SUM_W-1:0] c;
        if (s > SAT_HI) begin
            c = SAT_HI;
        end else if (s < SAT_LO) begin
            c = SAT_LO;
        end else begin
            c = s;
        end
        return OUT_W'(c >>> (WAVE_W - OUT_W));
    endfunction

    // Next-state logic: START, HOLD, RESTART and FINISH.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) state_d = S_RUN;
            S_RUN:  if (last)   state_d = accept ? S_RUN : S_IDLE;
            default:            state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            sum_i_q   <= '0;
            sum_q_q   <= '0;
            out_i     <= '0;
            out_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (state_q == S_RUN) begin
                idx_q   <= idx_q + 1'b1;
                sum_i_q <= sum_i_d;
                sum_q_q <= sum_q_d;
                if (last) begin
                    out_i     <= clip(sum_i_d);
                    out_q     <= clip(sum_q_d);
                    out_valid <= 1'b1;
                end
            end
            if (accept) begin
                idx_q   <= '0;
                sum_i_q <= '0;
                sum_q_q <= '0;
            end
        end
    end

    // R8: a sample is a single-cycle pulse.
    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R8: a sample only follows the last oscillator step.
    a_r8_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(state_q == S_RUN && idx_q == LAST_IDX));

    // R9: mid-sample strobes do not restart the oscillator walk.
    a_r9_midrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && idx_q != LAST_IDX)
        |=> (state_q == S_RUN && idx_q == $past(idx_q) + 1'b1));

    // R1: coming out of reset the sequencer waits idle.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (state_q == S_IDLE && !out_valid));

endmodule

// File: tb/tb_dds_sum_channel.sv
`timescale 1ns/1ps
module tb_dds_sum_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_stb = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [13:0] out_i, out_q;
    logic        out_valid;

    always #4 clk = ~clk;

    dds_sum_channel dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_stb  (sync_stb),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .out_i     (out_i),
        .out_q     (out_q),
        .out_valid (out_valid)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int edge_no  = 0;
    int last_acc = -100;
    bit finished = 1'b0;

    always @(posedge clk) edge_no <= edge_no + 1;

    // Reference register model.
    logic [31:0] m_ftw [5];
    logic [31:0] m_acc [5];
    int          m_amp [5];
    int          m_pow [5];
    bit          m_clr [5];

    typedef struct {
        int    i;
        int    q;
        int    due;
        string tag;
    } exp_t;
    exp_t sb[$];

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int half(int u);
        int f, m;
        f = u & 32767;
        m = (f * (32768 - f)) >>> 13;
        if (m > 32767) m = 32767;
        return ((u & 32768) != 0) ? -m : m;
    endfunction

    function automatic int clamp(int s);
        if (s > 32767) return 32767;
        if (s < -32768) return -32768;
        return s;
    endfunction

    task automatic model_sample(output int ei, output int eq);
        int si, sq, ph, c, s;
        si = 0;
        sq = 0;
        for (int n = 0; n < 5; n++) begin
            ph = (int'(m_acc[n] >> 16) + m_pow[n]) & 65535;
            s  = half(ph);
            c  = half((ph + 16384) & 65535);
            si += (c * m_amp[n]) >>> 15;
            sq += (s * m_amp[n]) >>> 15;
        end
        ei = (clamp(si) >>> 2) & 16'h3FFF;
        eq = (clamp(sq) >>> 2) & 16'h3FFF;
    endtask

    task automatic drive_idle(int n);
        repeat (n) begin
            @(negedge clk);
            sync_stb = 1'b0;
            wr_en    = 1'b0;
        end
    endtask

    task automatic drive_write(int osc, int sel, logic [31:0] d);
        @(negedge clk);
        sync_stb = 1'b0;
        wr_en    = 1'b1;
        wr_addr  = 4'(osc * 2 + sel);
        wr_data  = d;
        if (osc < 5) begin
            if (sel == 0) begin
                m_ftw[osc] = d;
            end else begin
                m_amp[osc] = int'(d[14:0]);
                m_clr[osc] = d[15];
                m_pow[osc] = int'(d[31:16]);
                if (d[15]) m_acc[osc] = '0;
            end
        end
    endtask

    task automatic drive_sync(string tag);
        exp_t e;
        int   ei, eq;
        @(negedge clk);
        wr_en    = 1'b0;
        sync_stb = 1'b1;
        if ((edge_no + 1) - last_acc >= 5) begin
            last_acc = edge_no + 1;
            for (int n = 0; n < 5; n++) begin
                m_acc[n] = m_clr[n] ? 32'h0 : (m_acc[n] + m_ftw[n]);
            end
            model_sample(ei, eq);
            e.i   = ei;
            e.q   = eq;
            e.due = edge_no + 1 + 5;
            e.tag = tag;
            sb.push_back(e);
        end
    endtask

    // Monitor: compares every produced sample against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid && !finished) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9", "unexpected sample", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(edge_no == e.due, "R8", "sample arrival edge", edge_no, e.due);
                check(out_i == 14'(e.i), e.tag, "out_i", int'(out_i), e.i);
                check(out_q == 14'(e.q), e.tag, "out_q", int'(out_q), e.q);
            end
        end
    end

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R8", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        for (int n = 0; n < 5; n++) begin
            m_ftw[n] = '0;
            m_acc[n] = '0;
            m_amp[n] = 32'h7FFF;
            m_pow[n] = 0;
            m_clr[n] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports.
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(out_i == '0, "R1", "out_i after reset", int'(out_i), 0);
        check(out_q == '0, "R1", "out_q after reset", int'(out_q), 0);

        // R1/R7: default full-scale amplitudes saturate the I sum.
        drive_sync("R1");
        drive_idle(7);

        // R3/R6: only oscillator 0 at half amplitude.
        drive_write(0, 1, 32'h0000_4000);
        for (int n = 1; n < 5; n++) drive_write(n, 1, 32'h0000_0000);
        drive_sync("R6");
        drive_idle(7);

        // R4/R5: two moving tones with offsets, back-to-back strobes.
        drive_write(0, 0, 32'h0800_0000);
        drive_write(0, 1, 32'h1000_7FFF);
        drive_write(1, 0, 32'h1234_5678);
        drive_write(1, 1, 32'hC000_2000);
        for (int k = 0; k < 8; k++) begin
            drive_sync("R4");
            drive_idle(4);
        end
        drive_idle(3);

        // R9: six consecutive strobe cycles, only the first and sixth count.
        for (int k = 0; k < 6; k++) drive_sync("R9");
        drive_idle(8);

        // R7/R10: all oscillators cleared, half-turn offset, full amplitude.
        for (int n = 0; n < 5; n++) drive_write(n, 1, 32'h8000_FFFF);
        for (int k = 0; k < 3; k++) begin
            drive_sync("R7");
            drive_idle(5);
        end
        drive_idle(2);

        // R10/R11: release oscillator 0, keep a second active tone.
        drive_write(0, 1, 32'h0000_7FFF);
        drive_write(1, 0, 32'h0100_0000);
        drive_write(1, 1, 32'h2000_3000);
        for (int n = 2; n < 5; n++) drive_write(n, 1, 32'h0000_8000);
        for (int k = 0; k < 3; k++) begin
            drive_sync("R10");
            drive_idle(4);
        end
        drive_idle(3);
        drive_write(0, 0, 32'h2000_0000);
        for (int k = 0; k < 3; k++) begin
            drive_sync("R11");
            drive_idle(4);
        end
        drive_idle(3);

        // R2: writes to absent oscillators 5..7 must not matter.
        for (int n = 5; n < 8; n++) begin
            drive_write(n, 0, 32'hFFFF_FFFF);
            drive_write(n, 1, 32'h5555_0001);
        end
        drive_sync("R2");
        drive_idle(5);
        drive_sync("R2");
        drive_idle(12);

        check(sb.size() == 0, "R8", "samples still outstanding", sb.size(), 0);
        report();
    end

endmodule